// File: doc/BRIEF.md
# Spindle Speed Phase Comparator

This block holds a spindle at its nominal speed by racing encoder edge pulses against a reference tick taken from a divided system clock. The two pulse streams push on opposite ends of a three-bit register. A reference tick moves the contents toward the upper bit and feeds a 1 into the lowest bit. An encoder pulse moves the contents toward the lowest bit and feeds a 0 into the upper bit. The middle bit is brought out as a pulse-width current command. It holds at 1 while the spindle lags. It toggles with about half duty once the encoder rate matches the reference. A late encoder pulse stretches its high time.

A settle detector watches the two outer bits of the register. After they have held still for a programmable number of reference ticks, it raises an at-speed flag. By default this is 270 ticks, about half a second at the nominal tick rate. Any movement of either outer bit drops the flag and starts the count again. Smoothing the command into an analog level is left to circuitry outside the block.

Top module: `spindle_phase_det`

## Requirements
- R1: `ref_tick` is a one-cycle pulse that repeats every DIV_RATIO clocks. After reset is released, the first pulse is high during the DIV_RATIO-th cycle.
- R2: An encoder pulse alone, with no reference tick in that cycle, shifts the register one place toward bit 0 and loads 0 into bit 2 (register bits [2:0]). With the default of 4168, the tick rate is about 540 Hz from a 2.25 MHz clock.
- R3: A reference tick alone shifts the register one place toward bit 2 and loads 1 into bit 0.
- R4: When an encoder pulse and a reference tick act on the same clock edge, the register keeps its value.
- R5: `phase` equals register bit 1. With no encoder pulses, it is 1 from the second reference tick onward.
- R6: `at_speed` rises once register bits 2 and 0 have stayed unchanged for SETTLE_TICKS reference ticks. It stays high while they remain unchanged.
- R7: A change in bit 2 or bit 0 drops `at_speed` one clock later and restarts the settle count.
- R8: Synchronous active-high reset clears the register to 000, the divider count to 0, the settle count to 0, and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_pulse | input | 1 | One-cycle pulse per encoder edge |
| ref_tick | output | 1 | Registered reference tick from the divider |
| phase | output | 1 | Middle register bit, used as the current command |
| at_speed | output | 1 | Spindle settled at nominal speed |

## Verification
The assertions assume that `enc_pulse` is a clean single-cycle strobe that is already synchronous to `clk`. They also assume that DIV_RATIO is at least 2, so two reference ticks never fall on neighbouring cycles. The bench drives `enc_pulse` only at falling edges and holds each pulse for exactly one cycle. Its encoder trains have periods near, above and below the reduced divider ratio. A pulse is deliberately placed on a tick cycle so that the cancel case occurs.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int SR_W = 3;
  typedef logic [SR_W-1:0] shreg_t;

  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_DOWN  = 2'd1,
    SH_UP    = 2'd2
  } shift_op_e;

  function automatic shift_op_e pick_op(input logic enc, input logic tick);
    if (enc && !tick)      return SH_DOWN;
    else if (tick && !enc) return SH_UP;
    else                   return SH_HOLD;
  endfunction
endpackage

// File: rtl/spd_ref_divider.sv
module spd_ref_divider #(
  parameter int DIV_RATIO = 4168
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/spd_shifter.sv
module spd_shifter
  import spd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   enc,
  input  logic   tick,
  output shreg_t sr
);
  shift_op_e op;

  always_comb op = pick_op(enc, tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else begin
      unique case (op)
        SH_DOWN: sr <= {1'b0, sr[SR_W-1:1]};
        SH_UP:   sr <= {sr[SR_W-2:0], 1'b1};
        default: sr <= sr;
      endcase
    end
  end

  p_enc_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (enc && !tick) |=> (sr[2] == 1'b0) && (sr[1:0] == $past(sr[2:1])));
  p_ref_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !enc) |=> (sr[0] == 1'b1) && (sr[2:1] == $past(sr[1:0])));
  p_cancel_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && enc) |=> $stable(sr));
endmodule

// File: rtl/spd_settle.sv
module spd_settle #(
  parameter int SETTLE_TICKS = 270
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] ends,
  output logic       at_speed
);
  localparam int SW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [SW-1:0] FULL = SW'(SETTLE_TICKS - 1);

  logic [1:0]    prev_ends;
  logic [SW-1:0] cnt;
  logic          moved;

  always_comb moved = (ends != prev_ends);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ends <= '0;
      cnt       <= '0;
      at_speed  <= 1'b0;
    end else begin
      prev_ends <= ends;
      if (moved) begin
        cnt      <= '0;
        at_speed <= 1'b0;
      end else if (tick && !at_speed) begin
        if (cnt == FULL) at_speed <= 1'b1;
        else             cnt      <= cnt + 1'b1;
      end
    end
  end

  p_drop_on_move_r7: assert property (@(posedge clk) disable iff (rst)
    moved |=> !at_speed);
  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(at_speed) |-> $past(tick));
endmodule

// File: rtl/spindle_phase_det.sv
module spindle_phase_det
  import spd_pkg::*;
#(
  parameter int DIV_RATIO    = 4168,
  parameter int SETTLE_TICKS = 270
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_pulse,
  output logic ref_tick,
  output logic phase,
  output logic at_speed
);
  shreg_t sr;

  spd_ref_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (ref_tick)
  );

  spd_shifter u_sr (
    .clk  (clk),
    .rst  (rst),
    .enc  (enc_pulse),
    .tick (ref_tick),
    .sr   (sr)
  );

  spd_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .tick     (ref_tick),
    .ends     ({sr[2], sr[0]}),
    .at_speed (at_speed)
  );

  always_comb phase = sr[1];

  p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && !enc_pulse && phase) |=> phase);
endmodule

// File: tb/spindle_phase_det_test.sv
module spindle_phase_det_test;
  localparam int DIV = 8;
  localparam int SET = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_pulse = 1'b0;
  logic ref_tick, phase, at_speed;

  int n_checks = 0;
  int n_fail = 0;

  spindle_phase_det #(.DIV_RATIO(DIV), .SETTLE_TICKS(SET)) uut (
    .clk(clk), .rst(rst), .enc_pulse(enc_pulse),
    .ref_tick(ref_tick), .phase(phase), .at_speed(at_speed)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_div = 0, m_tick = 0, m_sr = 0, m_prev = 0, m_cnt = 0, m_as = 0;
  always @(posedge clk) begin
    int ends_now, ntick, ndiv, nsr;
    if (rst) begin
      m_div = 0; m_tick = 0; m_sr = 0; m_prev = 0; m_cnt = 0; m_as = 0;
    end else begin
      ntick = (m_div == DIV - 1) ? 1 : 0;
      ndiv  = (m_div == DIV - 1) ? 0 : m_div + 1;
      nsr   = m_sr;
      if (enc_pulse && m_tick == 0) nsr = m_sr / 2;
      else if (m_tick == 1 && !enc_pulse) nsr = (m_sr * 2 + 1) % 8;
      ends_now = ((m_sr / 4) % 2) * 2 + (m_sr % 2);
      if (ends_now != m_prev) begin
        m_cnt = 0; m_as = 0;
      end else if (m_tick == 1 && m_as == 0) begin
        if (m_cnt == SET - 1) m_as = 1;
        else m_cnt = m_cnt + 1;
      end
      m_prev = ends_now;
      m_sr = nsr; m_div = ndiv; m_tick = ntick;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R1 ref_tick", int'(ref_tick), m_tick);
      check("R5 phase", int'(phase), (m_sr / 2) % 2);
      check("R6 at_speed", int'(at_speed), m_as);
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!ref_tick) @(negedge clk);
    end
  endtask

  task automatic enc_once();
    enc_pulse = 1'b1;
    @(negedge clk);
    enc_pulse = 1'b0;
  endtask

  task automatic enc_train(input int period, input int count);
    for (int k = 0; k < count; k++) begin
      enc_once();
      repeat (period - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 ref_tick in reset", int'(ref_tick), 0);
    check("R8 phase in reset", int'(phase), 0);
    check("R8 at_speed in reset", int'(at_speed), 0);
    rst = 1'b0;
    // R1: first tick visible in cycle DIV after release
    repeat (DIV - 1) @(negedge clk);
    check("R1 no early tick", int'(ref_tick), 0);
    @(negedge clk);
    check("R1 first tick", int'(ref_tick), 1);
    // R5: second tick makes phase 1 (sr 011)
    wait_ticks(1);
    @(negedge clk);
    check("R5 phase after two ticks", int'(phase), 1);
    // R6: ends stable after third tick, then SET ticks
    wait_ticks(SET + 2);
    @(negedge clk); @(negedge clk);
    check("R6 at_speed set", int'(at_speed), 1);
    // R2/R7: encoder pulse 111 -> 011
    enc_once();
    check("R2 phase after one enc", int'(phase), 1);
    @(negedge clk);
    check("R7 at_speed dropped", int'(at_speed), 0);
    enc_once();
    check("R2 phase after 011->001", int'(phase), 0);
    // R4: pulse on a tick cycle cancels (sr stays 001)
    while (!ref_tick) @(negedge clk);
    enc_once();
    check("R4 phase after cancel", int'(phase), 0);
    wait_ticks(1);
    @(negedge clk);
    check("R4 next tick gives 011", int'(phase), 1);
    // R3: clear to 000 then tick up
    enc_once(); enc_once();
    check("R3 cleared", int'(phase), 0);
    wait_ticks(1);
    @(negedge clk);
    check("R3 one tick 001", int'(phase), 0);
    wait_ticks(1);
    @(negedge clk);
    check("R3 two ticks 011", int'(phase), 1);
    // matched rate: phase toggles, ends stable
    enc_train(DIV, 40);
    check("R6 at_speed at matched rate", int'(at_speed), 1);
    enc_train(DIV + 3, 60);   // late pulses
    enc_train(DIV - 3, 60);   // early pulses
    enc_train(DIV, 30);
    repeat (20) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule